// File: doc/BRIEF.md
# Embedded-Clock Pixel Symbol Serializer

The block turns one 21-bit pixel word per pixel period into a 28-bit serial symbol and shifts it out one bit per fast-clock cycle. The fast clock runs at 28 times the pixel rate, and one clock domain drives the whole block. Each symbol opens with a high marker bit and closes with a low marker bit, so every symbol boundary has a guaranteed rising edge. The pixel word is scrambled with an additive keystream. The scrambled word and a low-speed control bit are then inverted as a group whenever that moves the running disparity towards zero, and a flag in the symbol records the inversion. In display use the 21 bits carry three 6-bit colour channels plus vertical sync, horizontal sync and data enable.

A matching receiver in the same block takes a serial input. It watches every one of the 28 bit phases for the low-to-high marker transition across a symbol boundary. It locks onto a phase that repeats for 8 symbols in a row, and it releases the lock after 4 missed markers at that phase. While locked it undoes the inversion and the scrambling, then presents the word and the control bit with a one-cycle valid pulse. The receiver takes its keystream from the transmit generator. It therefore expects `tx_bit_o` to reach `rx_bit_i` with no register in the path, and both halves must leave reset together.

Top module: `pix_link`

## Requirements
- R1: `tx_take_o` is high in the first cycle after reset and then every 28th cycle. `tx_data_i` and `tx_ctrl_i` are sampled at the clock edge that ends each cycle in which `tx_take_o` is high.
- R2: A sampled word goes out on `tx_bit_o` as one bit per cycle, starting in the cycle after the sample. Symbol position 0 is always 1, position 27 is always 0, and positions 24 to 26 are always 0.
- R3: Position 1+k carries data bit k XOR keystream bit k XOR the invert flag. The keystream comes from a 15-bit register that is all ones at reset. Each step computes new = s[14]^s[13] and shifts it in at bit 0. Keystream bit k is the new bit of step k+1, and each symbol consumes 21 steps.
- R4: Position 22 carries the control bit XOR the invert flag, and position 23 carries the invert flag.
- R5: The payload is positions 1 to 22. The running disparity is the sum over sent symbols of 2*(ones in the payload as sent) - 22. The flag is set exactly when the running disparity and the disparity of the uninverted payload are both nonzero and have the same sign. The running disparity stays within -22..22.
- R6: `rx_lock_o` rises in the cycle after the 8th consecutive marker transition seen at the same bit phase.
- R7: While locked, `rx_lock_o` falls in the cycle after the 4th consecutive missed marker at the locked phase, and not earlier.
- R8: While `rx_lock_o` is low, `rx_valid_o`, `rx_ctrl_o` and `rx_data_o` are all zero.
- R9: While locked over a direct link, each symbol's word and control bit appear on `rx_data_o`/`rx_ctrl_o` with a one-cycle `rx_valid_o` pulse, 28 cycles after the edge at which they were sampled.
- R10: During reset, `tx_take_o` is 1 and `tx_bit_o`, `rx_lock_o`, `rx_valid_o`, `rx_ctrl_o` and `rx_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock, 28x pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 21 | Pixel word to send |
| tx_ctrl_i | input | 1 | Control-channel bit to send |
| tx_take_o | output | 1 | Inputs are sampled at the end of this cycle |
| tx_bit_o | output | 1 | Serial symbol stream |
| rx_bit_i | input | 1 | Serial stream into the receiver |
| rx_data_o | output | 21 | Recovered pixel word |
| rx_ctrl_o | output | 1 | Recovered control bit |
| rx_valid_o | output | 1 | One-cycle pulse for a new recovered word |
| rx_lock_o | output | 1 | Receiver aligned to symbol boundaries |

## Verification
Counted in edges after reset release, word n is sampled at edge 28n+1, and its bit j is on the line in the cycle that follows edge 28n+1+j. Over a direct link the receiver lock rises after edge 198, and word n comes back with its valid pulse after edge 28n+29. The scoreboard keys every expected word to the edge at which it was taken and compares each valid pulse against the entry taken exactly 28 edges earlier. The lock and unlock checks sample one cycle before and one cycle after the marker edge computed for each event. All sampling happens on the falling clock edge, half a cycle after the register updates.

// File: rtl/pix_link_pkg.sv
package pix_link_pkg;
  localparam int unsigned KS_W = 15;
  typedef logic [KS_W-1:0] ks_state_t;

  // one additive-scrambler step, x^15 + x^14 + 1, new bit enters at bit 0
  function automatic ks_state_t ks_step(input ks_state_t s);
    return {s[KS_W-2:0], s[KS_W-1] ^ s[KS_W-2]};
  endfunction
endpackage

// File: rtl/pix_link_tx.sv
module pix_link_tx
  import pix_link_pkg::*;
#(
  parameter int unsigned DATA_W = 21,
  parameter int unsigned RSV_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctrl_i,
  output logic              take_o,
  output logic              bit_o,
  output logic [DATA_W-1:0] ks_o
);
  localparam int unsigned SYM_W = DATA_W + RSV_W + 4;
  localparam int unsigned CNT_W = $clog2(SYM_W);
  localparam int          PAY_W = DATA_W + 1;
  localparam int unsigned RD_W  = $clog2(PAY_W + 1) + 2;

  logic [CNT_W-1:0]       cnt_q;
  logic [SYM_W-1:0]       sym_q, sym_d;
  ks_state_t              lfsr_q, lfsr_d;
  logic [DATA_W-1:0]      ks_q, ks_d;
  logic signed [RD_W-1:0] rd_q;
  logic [PAY_W-1:0]       pay, pay_s;
  logic                   inv;
  int                     disp, disp_s, rd_nx;

  always_comb begin
    ks_state_t s;
    s = lfsr_q;
    for (int k = 0; k < int'(DATA_W); k++) begin
      s       = ks_step(s);
      ks_d[k] = s[0];
    end
    lfsr_d = s;
  end

  always_comb begin
    pay    = {ctrl_i, data_i ^ ks_d};
    disp   = 2 * $countones(pay) - PAY_W;
    // flip when it pulls the running sum back towards zero
    inv    = (rd_q > 0 && disp > 0) || (rd_q < 0 && disp < 0);
    pay_s  = inv ? ~pay : pay;
    disp_s = inv ? -disp : disp;
    rd_nx  = int'(rd_q) + disp_s;
    sym_d  = {1'b0, {RSV_W{1'b0}}, inv, pay_s, 1'b1};
  end

  assign take_o = (cnt_q == CNT_W'(SYM_W - 1));
  assign bit_o  = sym_q[cnt_q];
  assign ks_o   = ks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(SYM_W - 1);
      sym_q  <= '0;
      lfsr_q <= '1;
      ks_q   <= '0;
      rd_q   <= '0;
    end else if (take_o) begin
      cnt_q  <= '0;
      sym_q  <= sym_d;
      lfsr_q <= lfsr_d;
      ks_q   <= ks_d;
      rd_q   <= RD_W'(rd_nx);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_TAKE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o); // R1
  AST_MARK_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> bit_o); // R2
  AST_MARK_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !bit_o); // R2
  AST_RD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q <= RD_W'(PAY_W)) && (rd_q >= -RD_W'(PAY_W))); // R5
endmodule

// File: rtl/pix_link_rx.sv
module pix_link_rx #(
  parameter int unsigned DATA_W   = 21,
  parameter int unsigned RSV_W    = 3,
  parameter int unsigned LOCK_N   = 8,
  parameter int unsigned UNLOCK_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] ks_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ctrl_o,
  output logic              valid_o,
  output logic              lock_o
);
  localparam int unsigned SYM_W = DATA_W + RSV_W + 4;
  localparam int unsigned CNT_W = $clog2(SYM_W);
  localparam int unsigned MC_W  = $clog2(LOCK_N + 1);
  localparam int unsigned UC_W  = $clog2(UNLOCK_N + 1);

  logic [CNT_W-1:0] rc_q, ph_q, dec_ph;
  logic [SYM_W-2:0] sh_q;
  logic [SYM_W-1:0] win;
  logic [MC_W-1:0]  mc_q [SYM_W];
  logic [UC_W-1:0]  miss_q;
  logic             lock_q, hit, drop, dec, inv;

  assign hit    = !sh_q[SYM_W-2] && bit_i;  // low end of one symbol, high start of next
  assign drop   = lock_q && rc_q == ph_q && !hit && miss_q == UC_W'(UNLOCK_N - 1);
  assign dec_ph = (ph_q == '0) ? CNT_W'(SYM_W - 1) : ph_q - 1'b1;
  assign dec    = lock_q && rc_q == dec_ph;
  assign win    = {bit_i, sh_q};
  assign inv    = win[DATA_W+2];
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q <= '0;
      sh_q <= '0;
    end else begin
      rc_q <= (rc_q == CNT_W'(SYM_W - 1)) ? '0 : rc_q + 1'b1;
      sh_q <= {bit_i, sh_q[SYM_W-2:1]};
    end
  end

  // one marker-run counter per bit phase
  for (genvar p = 0; p < int'(SYM_W); p++) begin : g_phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mc_q[p] <= '0;
      else if (drop) mc_q[p] <= '0;
      else if (rc_q == CNT_W'(p)) begin
        if (!hit) mc_q[p] <= '0;
        else if (mc_q[p] != MC_W'(LOCK_N)) mc_q[p] <= mc_q[p] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      ph_q   <= '0;
      miss_q <= '0;
    end else if (!lock_q) begin
      if (hit && mc_q[rc_q] == MC_W'(LOCK_N - 1)) begin
        lock_q <= 1'b1;
        ph_q   <= rc_q;
        miss_q <= '0;
      end
    end else if (rc_q == ph_q) begin
      if (hit) miss_q <= '0;
      else if (drop) lock_q <= 1'b0;
      else miss_q <= miss_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ctrl_o  <= 1'b0;
    end else if (dec) begin
      valid_o <= 1'b1;
      data_o  <= win[DATA_W:1] ^ ks_i ^ {DATA_W{inv}};
      ctrl_o  <= win[DATA_W+1] ^ inv;
    end else begin
      valid_o <= 1'b0;
      if (!lock_q || drop) begin
        data_o <= '0;
        ctrl_o <= 1'b0;
      end
    end
  end

  AST_QUIET_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (!valid_o && !ctrl_o && data_o == '0)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_LOCK_ON_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(hit)); // R6
  AST_DROP_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(rc_q == ph_q && !hit)); // R7
endmodule

// File: rtl/pix_link.sv
module pix_link #(
  parameter int unsigned DATA_W   = 21,
  parameter int unsigned RSV_W    = 3,
  parameter int unsigned LOCK_N   = 8,
  parameter int unsigned UNLOCK_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_ctrl_i,
  output logic              tx_take_o,
  output logic              tx_bit_o,
  input  logic              rx_bit_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ctrl_o,
  output logic              rx_valid_o,
  output logic              rx_lock_o
);
  logic [DATA_W-1:0] ks;

  pix_link_tx #(.DATA_W(DATA_W), .RSV_W(RSV_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (tx_data_i),
    .ctrl_i (tx_ctrl_i),
    .take_o (tx_take_o),
    .bit_o  (tx_bit_o),
    .ks_o   (ks)
  );

  pix_link_rx #(.DATA_W(DATA_W), .RSV_W(RSV_W), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (rx_bit_i),
    .ks_i    (ks),
    .data_o  (rx_data_o),
    .ctrl_o  (rx_ctrl_o),
    .valid_o (rx_valid_o),
    .lock_o  (rx_lock_o)
  );
endmodule

// File: tb/pix_link_tb.sv
module pix_link_tb;
  typedef struct {
    logic [20:0] d;
    logic        c;
    int          e;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] tx_data = '0;
  logic        tx_ctrl = 1'b0;
  logic        tx_take, tx_bit, rx_ctrl, rx_valid, rx_lock;
  logic [20:0] rx_data;
  logic        brk = 1'b0;
  logic        cmp_en = 1'b1;
  int          edge_cnt = 0;
  int          total = 0, bad = 0, mode = 0, comps = 0;
  item_t       sb_q[$];
  item_t       hist[$];

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  pix_link u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_ctrl_i(tx_ctrl),
    .tx_take_o(tx_take), .tx_bit_o(tx_bit), .rx_bit_i(brk ? 1'b0 : tx_bit),
    .rx_data_o(rx_data), .rx_ctrl_o(rx_ctrl), .rx_valid_o(rx_valid), .rx_lock_o(rx_lock)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at edge %0d", req, act, exp, edge_cnt);
    end
  endtask

  task automatic wait_edge(input int e);
    while (edge_cnt < e) @(negedge clk);
  endtask

  // driver: new word whenever the serializer is about to sample
  initial begin
    int last;
    int nsym;
    item_t it;
    last = -1;
    nsym = 0;
    @(posedge rst_n);
    forever begin
      if (tx_take) begin
        case (mode)
          1: it.d = '0;
          2: it.d = '1;
          3: it.d = nsym[0] ? 21'h0AAAAA : 21'h155555;
          default: it.d = 21'($urandom);
        endcase
        it.c = 1'($urandom);
        it.e = edge_cnt + 1;
        if (last >= 0) chk(it.e - last == 28, "R1 take period", it.e - last, 28);
        else chk(it.e == 1, "R1 first take", it.e, 1);
        last = it.e;
        tx_data = it.d;
        tx_ctrl = it.c;
        sb_q.push_back(it);
        hist.push_back(it);
        nsym++;
      end
      @(negedge clk);
    end
  end

  // serial stream checker: framing, scrambling, balance
  initial begin
    logic [27:0] sbuf;
    logic [14:0] lf;
    logic [20:0] ks;
    logic [21:0] un;
    logic        nb, fexp;
    int          rd, draw, n, j;
    lf = '1;
    rd = 0;
    sbuf = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (edge_cnt >= 1) begin
        n = (edge_cnt - 1) / 28;
        j = (edge_cnt - 1) % 28;
        sbuf[j] = tx_bit;
        if (j == 27) begin
          for (int k = 0; k < 21; k++) begin
            nb = lf[14] ^ lf[13];
            lf = {lf[13:0], nb};
            ks[k] = nb;
          end
          chk(sbuf[0] == 1'b1 && sbuf[27] == 1'b0, "R2 markers", {sbuf[27], sbuf[0]}, 2'b01);
          chk(sbuf[26:24] == 3'b000, "R2 reserved", sbuf[26:24], 0);
          un = sbuf[23] ? ~sbuf[22:1] : sbuf[22:1];
          chk((un[20:0] ^ ks) == hist[n].d, "R3 scrambled data", un[20:0] ^ ks, hist[n].d);
          chk(un[21] == hist[n].c, "R4 control slot", un[21], hist[n].c);
          draw = 2 * $countones(un) - 22;
          fexp = (rd > 0 && draw > 0) || (rd < 0 && draw < 0);
          chk(sbuf[23] == fexp, "R5 invert flag", sbuf[23], fexp);
          rd += 2 * $countones(sbuf[22:1]) - 22;
          chk(rd <= 22 && rd >= -22, "R5 disparity bound", rd, 22);
        end
      end
    end
  end

  // receive monitor / scoreboard
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (!rx_lock) begin
        chk(!rx_valid && rx_data == '0 && !rx_ctrl, "R8 quiet while unlocked",
            {rx_valid, rx_ctrl, rx_data}, 0);
      end else if (rx_valid && cmp_en) begin
        while (sb_q.size() > 0 && sb_q[0].e < edge_cnt - 28) void'(sb_q.pop_front());
        if (sb_q.size() == 0) chk(1'b0, "R9 no expected word", 0, 1);
        else begin
          chk(sb_q[0].e == edge_cnt - 28, "R9 latency", sb_q[0].e, edge_cnt - 28);
          chk(rx_data == sb_q[0].d && rx_ctrl == sb_q[0].c, "R9 word",
              {rx_ctrl, rx_data}, {sb_q[0].c, sb_q[0].d});
          comps++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b, r, c0;
    repeat (3) @(negedge clk);
    chk(tx_take == 1'b1, "R10 take in reset", tx_take, 1);
    chk(!tx_bit && !rx_lock && !rx_valid && !rx_ctrl && rx_data == '0, "R10 outputs in reset",
        {tx_bit, rx_lock, rx_valid, rx_ctrl, rx_data}, 0);
    rst_n = 1'b1;

    wait_edge(197);
    chk(rx_lock == 1'b0, "R6 no lock after 7 markers", rx_lock, 0);
    wait_edge(198);
    chk(rx_lock == 1'b1, "R6 lock after 8 markers", rx_lock, 1);

    wait_edge(edge_cnt + 28 * 30);
    mode = 1;
    wait_edge(edge_cnt + 28 * 20);
    mode = 2;
    wait_edge(edge_cnt + 28 * 20);
    mode = 3;
    wait_edge(edge_cnt + 28 * 20);
    mode = 0;
    chk(comps >= 85, "R9 words delivered", comps, 85);

    // cut the link: all markers vanish
    while (edge_cnt % 28 != 10) @(negedge clk);
    b = edge_cnt;
    brk = 1'b1;
    cmp_en = 1'b0;
    wait_edge(b + 20 + 83);
    chk(rx_lock == 1'b1, "R7 held through 3 misses", rx_lock, 1);
    wait_edge(b + 20 + 84);
    chk(rx_lock == 1'b0, "R7 drop after 4 misses", rx_lock, 0);

    wait_edge(edge_cnt + 28 * 3);
    while (edge_cnt % 28 != 10) @(negedge clk);
    r = edge_cnt;
    brk = 1'b0;
    wait_edge(r + 215);
    chk(rx_lock == 1'b0, "R6 relock not early", rx_lock, 0);
    wait_edge(r + 216);
    chk(rx_lock == 1'b1, "R6 relock after 8 markers", rx_lock, 1);
    cmp_en = 1'b1;
    c0 = comps;
    wait_edge(edge_cnt + 28 * 40);
    chk(comps - c0 >= 39, "R9 words after relock", comps - c0, 39);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule